// File: doc/BRIEF.md
# Oscillator Reprogramming Sequencer

This block loads a new frequency setting into a programmable clock oscillator. The oscillator is reached through a small local register window. On a start strobe the block captures three codes: a 3-bit high-speed divider code, a 7-bit output divider code and a 38-bit fractional multiplier word. It packs them into six byte registers. It then drives a fixed handshake on a control register, which selects fabric control, loads the new word with a write trigger, and closes with a reset trigger. Fixed waits separate the phases.

Between the load and the closing reset, the block reads the six byte registers back and compares them with what it wrote. If any byte differs, the whole attempt runs again, up to a parameterised number of attempts (three by default). At the end the block pulses `done` for one cycle. It reports `success` and the number of retries it needed, and both values stay valid until the next run ends. The wait length is given in clock cycles. A real board uses a value between 10 ms and 15 ms, and a simulation uses a short one.

The register window is a simple master port. Each cycle it carries at most one write or one read. Read data is taken the cycle after the read strobe.

Top module: `osc_reprog_seq`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. The three codes are captured in the accepting cycle. A `start` while busy, and any change of the codes after acceptance, has no effect on the bus operations or the results.
- R2: The control register sits at address 0x04. Its bits are: bit 9 write trigger, bit 8 reset trigger, bit 7 fabric-control select, bit 6 enable. Every control write sets enable. The attempt writes these values in this order: 0x00C0, 0x0240, 0x00C0, 0x01C0, 0x0040.
- R3: Byte k (k = 0..5) is written to address 0x08 + 4k, with data bits 15:8 zero. The byte contents are as follows. Byte 0 is {divider code[2:0], output divider[6:2]}. Byte 1 is {output divider[1:0], multiplier[37:32]}. Bytes 2 to 5 hold multiplier[31:0], most significant byte first.
- R4: An attempt starts in the cycle after acceptance, or in the cycle after a failed evaluation. It writes control 0x00C0 and waits. It then writes bytes 0..5 on consecutive cycles, writes 0x0240, waits, writes 0x00C0 and waits.
- R5: After that, the attempt reads addresses 0x08..0x1C on six consecutive cycles. It then writes 0x01C0, waits, writes 0x0040 and waits.
- R6: Every wait lasts exactly `WAIT_CYC` cycles, with no bus operation.
- R7: One idle evaluation cycle follows the last wait. It compares bits 7:0 of each read-back byte with the byte written. A mismatch starts a new attempt in the next cycle, unless `MAX_TRIES` attempts have already run.
- R8: `done` is high for exactly one cycle, right after the final evaluation cycle. In that cycle `success` is 1 if the last attempt matched and `retries` equals the number of attempts minus one. Both outputs hold until the next run ends. If every attempt fails, `success` is 0 and `retries` is `MAX_TRIES`-1.
- R9: After reset the block is idle: `busy`, `done`, `reg_we`, `reg_re`, `success` and `retries` are all zero.
- R10: Each cycle carries at most one bus operation, and there is no bus operation while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request strobe |
| hsdiv_code | input | 3 | High-speed divider register code |
| n1_code | input | 7 | Output divider register code |
| rfreq | input | 38 | Fractional multiplier word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Last run verified correctly |
| retries | output | TRY_W (2) | Retries used by the last run |
| reg_we | output | 1 | Register window write strobe |
| reg_re | output | 1 | Register window read strobe |
| reg_addr | output | 8 | Register window byte address |
| reg_wdata | output | 16 | Register window write data |
| reg_rdata | input | 16 | Read data, valid the cycle after `reg_re` |

## Verification
The retry path is the hardest to reach, because a correct register window always reads back what was written. The bench's window model flips a bit of the returned data for a chosen number of attempts. It counts the reset-trigger control writes to know when one attempt ends and the next begins. Runs with zero, one, two and three corrupted attempts cover first-time success, both retry depths and exhaustion. One run also raises `start` with different codes partway through the sequence, to show that the captured frame is not disturbed.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;

    localparam int BYTES       = 6;
    localparam int IDX_W       = $clog2(BYTES);
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 16;
    localparam int BYTE_STRIDE = 4;

    localparam logic [ADDR_W-1:0] CTL_ADDR  = 8'h04;
    localparam logic [ADDR_W-1:0] BYTE_BASE = 8'h08;

    // control bit positions (decoded by the register window)
    localparam int CB_WRITE = 9;
    localparam int CB_RESET = 8;
    localparam int CB_SEL   = 7;
    localparam int CB_EN    = 6;

    typedef logic [BYTES-1:0][7:0] frame_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTL_A,
        S_WR,
        S_CTL_B,
        S_CTL_C,
        S_RD,
        S_CTL_D,
        S_CTL_E,
        S_WAIT,
        S_EVAL,
        S_DONE
    } seq_state_t;

    function automatic logic [DATA_W-1:0] ctl_word(input logic wr_trig,
                                                   input logic rs_trig,
                                                   input logic sel);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[CB_EN]    = 1'b1;
        w[CB_WRITE] = wr_trig;
        w[CB_RESET] = rs_trig;
        w[CB_SEL]   = sel;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] byte_addr(input logic [IDX_W-1:0] k);
        logic [ADDR_W-1:0] off;
        off = ADDR_W'(k) * ADDR_W'(BYTE_STRIDE);
        return BYTE_BASE + off;
    endfunction

    function automatic frame_t pack_frame(input logic [2:0]  hs,
                                          input logic [6:0]  n1,
                                          input logic [37:0] rf);
        frame_t f;
        f[0] = {hs, n1[6:2]};
        f[1] = {n1[1:0], rf[37:32]};
        f[2] = rf[31:24];
        f[3] = rf[23:16];
        f[4] = rf[15:8];
        f[5] = rf[7:0];
        return f;
    endfunction

endpackage

// File: rtl/osc_wait_timer.sv
module osc_wait_timer #(
    parameter int WAIT_CYC = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC + 1) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign last = run && (cnt == CW'(WAIT_CYC - 1));

endmodule

// File: rtl/osc_frame_pack.sv
module osc_frame_pack
    import osc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [2:0]  hsdiv_code,
    input  logic [6:0]  n1_code,
    input  logic [37:0] rfreq,
    output frame_t      frame
);
    always_ff @(posedge clk) begin
        if (rst)
            frame <= '0;
        else if (load)
            frame <= pack_frame(hsdiv_code, n1_code, rfreq);
    end

endmodule

// File: rtl/osc_readback_cmp.sv
module osc_readback_cmp
    import osc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             cap,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [7:0]       cap_byte,
    input  frame_t           frame,
    output logic             mismatch
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            mismatch <= 1'b0;
        else if (cap && (cap_byte != frame[cap_idx]))
            mismatch <= 1'b1;
    end

endmodule

// File: rtl/osc_reprog_seq.sv
module osc_reprog_seq
    import osc_seq_pkg::*;
#(
    parameter int WAIT_CYC  = 1000000,
    parameter int MAX_TRIES = 3,
    localparam int TRY_W    = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        hsdiv_code,
    input  logic [6:0]        n1_code,
    input  logic [37:0]       rfreq,
    output logic              busy,
    output logic              done,
    output logic              success,
    output logic [TRY_W-1:0]  retries,
    output logic              reg_we,
    output logic              reg_re,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    seq_state_t       state, ret_state;
    logic [IDX_W-1:0] idx;
    logic [TRY_W-1:0] attempt;
    logic             rd_pend;
    logic [IDX_W-1:0] rd_idx_q;
    logic             t_last;
    logic             mismatch;
    logic             load;
    frame_t           frame;

    assign load = (state == S_IDLE) && start;
    assign busy = (state != S_IDLE);
    assign done = (state == S_DONE);

    osc_frame_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .hsdiv_code (hsdiv_code),
        .n1_code    (n1_code),
        .rfreq      (rfreq),
        .frame      (frame)
    );

    osc_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == S_WAIT),
        .last (t_last)
    );

    osc_readback_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .clear    (state == S_CTL_A),
        .cap      (rd_pend),
        .cap_idx  (rd_idx_q),
        .cap_byte (reg_rdata[7:0]),
        .frame    (frame),
        .mismatch (mismatch)
    );

    // bus drive, purely from state
    always_comb begin
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        unique case (state)
            S_CTL_A, S_CTL_C: begin
                reg_we    = 1'b1;
                reg_addr  = CTL_ADDR;
                reg_wdata = ctl_word(1'b0, 1'b0, 1'b1);
            end
            S_CTL_B: begin
                reg_we    = 1'b1;
                reg_addr  = CTL_ADDR;
                reg_wdata = ctl_word(1'b1, 1'b0, 1'b0);
            end
            S_CTL_D: begin
                reg_we    = 1'b1;
                reg_addr  = CTL_ADDR;
                reg_wdata = ctl_word(1'b0, 1'b1, 1'b1);
            end
            S_CTL_E: begin
                reg_we    = 1'b1;
                reg_addr  = CTL_ADDR;
                reg_wdata = ctl_word(1'b0, 1'b0, 1'b0);
            end
            S_WR: begin
                reg_we    = 1'b1;
                reg_addr  = byte_addr(idx);
                reg_wdata = {8'h00, frame[idx]};
            end
            S_RD: begin
                reg_re    = 1'b1;
                reg_addr  = byte_addr(idx);
            end
            default: ;
        endcase
    end

    // read-data capture lags the strobe by one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend  <= 1'b0;
            rd_idx_q <= '0;
        end else begin
            rd_pend  <= (state == S_RD);
            rd_idx_q <= idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ret_state <= S_IDLE;
            idx       <= '0;
            attempt   <= '0;
            success   <= 1'b0;
            retries   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        attempt <= '0;
                        state   <= S_CTL_A;
                    end
                end
                S_CTL_A: begin
                    ret_state <= S_WR;
                    state     <= S_WAIT;
                end
                S_WR: begin
                    if (idx == IDX_W'(BYTES - 1)) begin
                        idx   <= '0;
                        state <= S_CTL_B;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_CTL_B: begin
                    ret_state <= S_CTL_C;
                    state     <= S_WAIT;
                end
                S_CTL_C: begin
                    ret_state <= S_RD;
                    state     <= S_WAIT;
                end
                S_RD: begin
                    if (idx == IDX_W'(BYTES - 1)) begin
                        idx   <= '0;
                        state <= S_CTL_D;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_CTL_D: begin
                    ret_state <= S_CTL_E;
                    state     <= S_WAIT;
                end
                S_CTL_E: begin
                    ret_state <= S_EVAL;
                    state     <= S_WAIT;
                end
                S_WAIT: begin
                    if (t_last)
                        state <= ret_state;
                end
                S_EVAL: begin
                    if (!mismatch) begin
                        success <= 1'b1;
                        retries <= attempt;
                        state   <= S_DONE;
                    end else if (attempt == TRY_W'(MAX_TRIES - 1)) begin
                        success <= 1'b0;
                        retries <= attempt;
                        state   <= S_DONE;
                    end else begin
                        attempt <= attempt + 1'b1;
                        state   <= S_CTL_A;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/osc_reprog_seq_chk.sv
module osc_reprog_seq_chk #(
    parameter int MAX_TRIES = 3,
    localparam int TRY_W    = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             success,
    input logic [TRY_W-1:0] retries,
    input logic             reg_we,
    input logic             reg_re,
    input logic [7:0]       reg_addr,
    input logic [15:0]      reg_wdata
);
    AST_SINGLE_OP: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(reg_we || reg_re)); // R10

    AST_CTL_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 8'h04) |-> reg_wdata[6]); // R2

    AST_CTL_TRIGGERS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 8'h04) |-> !(reg_wdata[9] && reg_wdata[8])); // R2

    AST_BYTE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr != 8'h04) |->
        (reg_wdata[15:8] == 8'h00 && reg_addr[1:0] == 2'b00 &&
         reg_addr >= 8'h08 && reg_addr <= 8'h1C)); // R3

    AST_START_TO_BUS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=>
        (reg_we && reg_addr == 8'h04 && reg_wdata == 16'h00C0)); // R4

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(success) && $stable(retries))); // R8

    AST_FAIL_RETRIES: assert property (@(posedge clk) disable iff (rst)
        (done && !success) |-> (retries == TRY_W'(MAX_TRIES - 1))); // R7

endmodule

bind osc_reprog_seq osc_reprog_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .success   (success),
    .retries   (retries),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/osc_reprog_seq_tb.sv
module osc_reprog_seq_tb;
    localparam int W     = 5;
    localparam int TRIES = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  hsdiv_code = '0;
    logic [6:0]  n1_code = '0;
    logic [37:0] rfreq = '0;
    logic        busy, done, success;
    logic [1:0]  retries;
    logic        reg_we, reg_re;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata = '0;

    always #5 clk = ~clk;

    osc_reprog_seq #(.WAIT_CYC(W), .MAX_TRIES(TRIES)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .hsdiv_code(hsdiv_code), .n1_code(n1_code), .rfreq(rfreq),
        .busy(busy), .done(done), .success(success), .retries(retries),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // register window model with optional read corruption
    logic [15:0] win [0:15];
    int bad_left = 0;
    initial for (int i = 0; i < 16; i++) win[i] = '0;

    always @(posedge clk) begin
        if (reg_re)
            reg_rdata <= win[reg_addr[5:2]] ^ ((bad_left > 0) ? 16'h0001 : 16'h0000);
        if (reg_we) begin
            win[reg_addr[5:2]] <= reg_wdata;
            if (reg_addr == 8'h04 && reg_wdata == 16'h01C0 && bad_left > 0)
                bad_left <= bad_left - 1;
        end
    end

    // expected per-cycle behaviour
    typedef struct {
        bit        we;
        bit        re;
        bit [7:0]  addr;
        bit [15:0] wd;
        bit        bsy;
        bit        dn;
        bit        succ;
        int        rtr;
        int        req;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   chk_on = 1'b0;
    bit   finished = 1'b0;
    bit   exp_s = 1'b0;
    int   exp_r = 0;

    task automatic push(bit we, bit re, bit [7:0] a, bit [15:0] d, bit bsy, int req);
        exp_t e;
        e = '{we:we, re:re, addr:a, wd:d, bsy:bsy, dn:1'b0, succ:1'b0, rtr:0, req:req};
        q.push_back(e);
    endtask

    task automatic push_wait(int req);
        for (int i = 0; i < W; i++) push(0, 0, 8'h00, 16'h0000, 1, req);
    endtask

    function automatic bit [7:0] fbyte(int k, bit [2:0] hs, bit [6:0] n1, bit [37:0] rf);
        case (k)
            0: return {hs, n1[6:2]};
            1: return {n1[1:0], rf[37:32]};
            2: return rf[31:24];
            3: return rf[23:16];
            4: return rf[15:8];
            default: return rf[7:0];
        endcase
    endfunction

    task automatic push_attempt(bit [2:0] hs, bit [6:0] n1, bit [37:0] rf);
        push(1, 0, 8'h04, 16'h00C0, 1, 4);                       // R4
        push_wait(6);                                            // R6
        for (int k = 0; k < 6; k++)
            push(1, 0, 8'(8 + 4 * k), {8'h00, fbyte(k, hs, n1, rf)}, 1, 3); // R3
        push(1, 0, 8'h04, 16'h0240, 1, 2);                       // R2
        push_wait(6);
        push(1, 0, 8'h04, 16'h00C0, 1, 4);                       // R4
        push_wait(6);
        for (int k = 0; k < 6; k++)
            push(0, 1, 8'(8 + 4 * k), 16'h0000, 1, 5);           // R5
        push(1, 0, 8'h04, 16'h01C0, 1, 5);                       // R5
        push_wait(6);
        push(1, 0, 8'h04, 16'h0040, 1, 5);                       // R5
        push_wait(6);
        push(0, 0, 8'h00, 16'h0000, 1, 7);                       // R7 evaluation cycle
    endtask

    task automatic push_done(bit s, int r);
        exp_t e;
        e = '{we:0, re:0, addr:0, wd:0, bsy:1, dn:1, succ:s, rtr:r, req:8}; // R8
        q.push_back(e);
    endtask

    task automatic chk(string what, int req, longint act, longint expv);
        if (act != expv) begin
            miscompares++;
            $display("FAIL R%0d %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            exp_t e;
            if (q.size() > 0) e = q.pop_front();
            else e = '{we:0, re:0, addr:0, wd:0, bsy:0, dn:0, succ:0, rtr:0, req:10}; // R10
            if (e.dn) begin
                exp_s = e.succ;
                exp_r = e.rtr;
            end
            vectors++;
            chk("reg_we",  e.req, reg_we, e.we);
            chk("reg_re",  e.req, reg_re, e.re);
            if (e.we || e.re) chk("reg_addr", e.req, reg_addr, e.addr);
            if (e.we) chk("reg_wdata", e.req, reg_wdata, e.wd);
            chk("busy",    e.req, busy, e.bsy);
            chk("done",    e.req, done, e.dn);
            chk("success", 8, success, exp_s);
            chk("retries", 8, retries, exp_r);
        end
    end

    task automatic run_case(bit [2:0] hs, bit [6:0] n1, bit [37:0] rf, int bad, bit mid_start);
        int att;
        @(posedge clk); #2;
        hsdiv_code = hs; n1_code = n1; rfreq = rf;
        start = 1'b1;
        bad_left = bad;
        push(0, 0, 8'h00, 16'h0000, 0, 1);   // R1 still idle in this cycle
        att = (bad < TRIES) ? bad + 1 : TRIES;
        for (int a = 0; a < att; a++) push_attempt(hs, n1, rf);
        push_done(bad < TRIES, att - 1);     // R7 R8
        @(posedge clk); #2;
        start = 1'b0;
        hsdiv_code = ~hs; n1_code = ~n1; rfreq = ~rf;  // R1 codes change after capture
        if (mid_start) begin
            repeat (15) @(posedge clk);
            #2 start = 1'b1;                 // R1 ignored while busy
            @(posedge clk); #2 start = 1'b0;
        end
        while (q.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        chk_on = 1'b1;                       // R9 reset state checked on idle cycles
        repeat (3) @(posedge clk);
        run_case(3'b101, 7'b1100110, 38'h2A_1234_5678, 0, 1'b1);
        run_case(3'b010, 7'b0011001, 38'h15_89AB_CDEF, 1, 1'b0);
        run_case(3'b111, 7'b1111111, 38'h3F_FFFF_FFFF, 2, 1'b0);
        run_case(3'b000, 7'b0000001, 38'h00_0000_0000, 3, 1'b1);
        run_case(3'b011, 7'b1000000, 38'h20_8000_0001, 0, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL R8 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule